// File: doc/BRIEF.md
# Programmable Interrupt Controller with Build-Time Variants

This block collects 32 external interrupt lines beside a CPU core and turns them into a single request to the core. Software reaches it through a small register port carrying a one-bit register select: select 0 is the enable mask and select 1 is the pending status. The request to the core is raised while any line is both pending and enabled. A lowest-pending-line index, with its own valid flag, is also provided. Software can use it to dispatch pending lines from the lowest number upward.

A build-time parameter picks how the status register behaves. In the live variant, each status bit is just the synchronized input line. In the edge variant, rising edges are latched and software writes ones to clear bits. In the latch variant, an active level is latched and software writes zeros to clear bits. Under that rule, a read-modify-write that clears only one bit leaves every other latch intact.

Top module: `pic_ctrl`

## Requirements
- R1: While reset is held and right after it, the mask and status registers read 0, the core request and the valid flag are low, and the read data is 0.
- R2: A write with select 0 loads the mask register with the write data exactly, and a later read with select 0 returns that value.
- R3: In the live variant, each status bit equals its input line delayed by two clock edges of synchronization, and writes with select 1 change nothing.
- R4: In the edge variant, a 0-to-1 change of a synchronized line sets its status bit, and the bit stays set after the line returns to 0.
- R5: In the edge variant, a status write clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R6: In the latch variant, a synchronized line at 1 sets its status bit, and the bit stays set after the line returns to 0.
- R7: In the latch variant, a status write clears each bit whose write-data bit is 0 (when its line is low) and leaves each bit whose write-data bit is 1 unchanged.
- R8: In the edge and latch variants, when a set condition and a clear fall on the same bit in the same cycle, the bit ends up set.
- R9: The core request is 1 exactly when at least one bit is 1 in both status and mask.
- R10: The valid flag equals the core request. While it is 1, the 5-bit index gives the lowest bit number set in both status and mask.
- R11: A read request (request 1, write 0) returns the selected register on the read-data port one clock later: select 0 gives mask, select 1 gives status. The value is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Raw interrupt inputs, one per line |
| sreg_req | input | 1 | Register access request |
| sreg_we | input | 1 | 1 = write, 0 = read |
| sreg_sel | input | 1 | 0 = mask register, 1 = status register |
| sreg_wdata | input | 32 | Write data |
| sreg_rdata | output | 32 | Read data, valid one cycle after a read request |
| core_irq | output | 1 | Interrupt request to the core |
| pend_idx | output | 5 | Lowest pending enabled line number |
| pend_valid | output | 1 | High when pend_idx is meaningful |

## Verification
The two functions that can collide are a software clear of a status bit and a fresh set of that same bit by its line. The bench provokes a collision for the edge variant by timing a raw rising input so that its synchronized edge reaches the status register on exactly the clock that a write-one clear takes effect. For the latch variant, it writes zero to a bit whose line is still high. In both cases the collision is judged by reading the status back: the bit must still be set. A follow-up clear after the line has gone quiet must then remove it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    PIC_LIVE      = 2'd0,
    PIC_EDGE_W1C  = 2'd1,
    PIC_LATCH_W0C = 2'd2
  } pic_variant_e;

  localparam int unsigned PIC_LINES = 32;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pic_status.sv
module pic_status
  import pic_pkg::*;
#(
  parameter pic_variant_e VARIANT = PIC_LATCH_W0C,
  parameter int           W       = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status
);
  if (VARIANT == PIC_LIVE) begin : g_live
    logic live_unused;
    assign live_unused = wr_en ^ (^wdata) ^ clk ^ rst_n;
    assign status = lvl;
  end else begin : g_held
    logic [W-1:0] stat_q, stat_d, set_v, clr_v;

    if (VARIANT == PIC_EDGE_W1C) begin : g_edge
      logic [W-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
      end
      always_comb begin
        set_v = lvl & ~prev_q;
        clr_v = wr_en ? wdata : '0;
      end

      p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));
      p_edge_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((status & $past(wdata & ~set_v)) == '0));
    end else begin : g_latch
      always_comb begin
        set_v = lvl;
        clr_v = wr_en ? ~wdata : '0;
      end

      p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|lvl) |=> ((status & $past(lvl)) == $past(lvl)));
      p_latch_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((status & $past(stat_q & wdata)) == $past(stat_q & wdata)));
      p_latch_w0c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((status & $past(~wdata & ~lvl)) == '0));
    end

    // a set in the same cycle as a clear wins (R8)
    always_comb stat_d = (stat_q & ~clr_v) | set_v;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
    end

    assign status = stat_q;
  end
endmodule

// File: rtl/pic_first.sv
module pic_first #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          valid
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    valid = |vec;
  end

  p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter pic_variant_e VARIANT     = PIC_LATCH_W0C,
  parameter int           LINES       = PIC_LINES,
  parameter int           SYNC_STAGES = 2,
  localparam int          IDX_W       = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_lines,
  input  logic             sreg_req,
  input  logic             sreg_we,
  input  logic             sreg_sel,
  input  logic [LINES-1:0] sreg_wdata,
  output logic [LINES-1:0] sreg_rdata,
  output logic             core_irq,
  output logic [IDX_W-1:0] pend_idx,
  output logic             pend_valid
);
  logic [LINES-1:0] lvl_sync, status, mask_q, mask_d, rd_q, rd_d, armed;
  logic             mask_we, stat_we, rd_en;

  pic_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_lines), .q(lvl_sync)
  );

  always_comb begin
    mask_we = sreg_req & sreg_we & ~sreg_sel;
    stat_we = sreg_req & sreg_we &  sreg_sel;
    rd_en   = sreg_req & ~sreg_we;
    mask_d  = mask_we ? sreg_wdata : mask_q;
    rd_d    = rd_en ? (sreg_sel ? status : mask_q) : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rd_q   <= '0;
    end else begin
      mask_q <= mask_d;
      rd_q   <= rd_d;
    end
  end

  pic_status #(.VARIANT(VARIANT), .W(LINES)) u_status (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync),
    .wr_en(stat_we), .wdata(sreg_wdata), .status(status)
  );

  assign armed    = status & mask_q;
  assign core_irq = |armed;

  pic_first #(.W(LINES), .IW(IDX_W)) u_first (
    .clk(clk), .rst_n(rst_n), .vec(armed), .idx(pend_idx), .valid(pend_valid)
  );

  assign sreg_rdata = rd_q;

  p_mask_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_req && sreg_we && !sreg_sel) |=> (mask_q == $past(sreg_wdata)));
  p_irq_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq == pend_valid);
  p_rd_stat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_req && !sreg_we && sreg_sel) |=> (sreg_rdata == $past(status)));
  p_rd_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_req && !sreg_we && !sreg_sel) |=> (sreg_rdata == $past(mask_q)));
endmodule

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
  import pic_pkg::*;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        sreg_req = 1'b0, sreg_we = 1'b0, sreg_sel = 1'b0;
  logic [31:0] sreg_wdata = '0;

  logic [31:0] rd_lat, rd_edg, rd_liv;
  logic        irq_lat, irq_edg, irq_liv;
  logic [4:0]  idx_lat, idx_edg, idx_liv;
  logic        vld_lat, vld_edg, vld_liv;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pic_ctrl #(.VARIANT(PIC_LATCH_W0C)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sreg_req(sreg_req),
    .sreg_we(sreg_we), .sreg_sel(sreg_sel), .sreg_wdata(sreg_wdata),
    .sreg_rdata(rd_lat), .core_irq(irq_lat), .pend_idx(idx_lat), .pend_valid(vld_lat));

  pic_ctrl #(.VARIANT(PIC_EDGE_W1C)) uut_edge (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sreg_req(sreg_req),
    .sreg_we(sreg_we), .sreg_sel(sreg_sel), .sreg_wdata(sreg_wdata),
    .sreg_rdata(rd_edg), .core_irq(irq_edg), .pend_idx(idx_edg), .pend_valid(vld_edg));

  pic_ctrl #(.VARIANT(PIC_LIVE)) uut_live (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sreg_req(sreg_req),
    .sreg_we(sreg_we), .sreg_sel(sreg_sel), .sreg_wdata(sreg_wdata),
    .sreg_rdata(rd_liv), .core_irq(irq_liv), .pend_idx(idx_liv), .pend_valid(vld_liv));

  typedef struct packed {
    logic [31:0] lines;
    logic [31:0] mask;
    logic [4:0]  idx;
    logic        vld;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 5'd0,  1'b1},
    '{32'h8000_0000, 32'hFFFF_FFFF, 5'd31, 1'b1},
    '{32'h8000_0001, 32'h8000_0000, 5'd31, 1'b1},
    '{32'h00F0_0000, 32'h0000_FFFF, 5'd0,  1'b0},
    '{32'h0000_0C00, 32'h0000_0800, 5'd11, 1'b1},
    '{32'h0000_0000, 32'hFFFF_FFFF, 5'd0,  1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] data);
    @(negedge clk);
    sreg_req = 1'b1; sreg_we = 1'b1; sreg_sel = sel; sreg_wdata = data;
    @(negedge clk);
    sreg_req = 1'b0; sreg_we = 1'b0;
  endtask

  task automatic reg_read(input logic sel);
    @(negedge clk);
    sreg_req = 1'b1; sreg_we = 1'b0; sreg_sel = sel;
    @(negedge clk);
    sreg_req = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1: state during and after reset
    irq_lines = 32'hFFFF_FFFF;
    wait_cyc(3);
    check("R1 rdata in reset", rd_lat | rd_edg | rd_liv, 32'h0);
    check("R1 irq in reset", {irq_lat, irq_edg, irq_liv, vld_lat, vld_edg, vld_liv}, 32'h0);
    irq_lines = '0;
    rst_n = 1'b1;
    wait_cyc(3);
    reg_read(1'b0);
    check("R1 mask after reset", rd_lat, 32'h0);
    reg_read(1'b1);
    check("R1 status after reset", rd_lat | rd_edg | rd_liv, 32'h0);

    // R2 / R11: mask write and read-back, select decoding
    reg_write(1'b0, 32'hA5A5_5A5A);
    reg_read(1'b0);
    check("R2 mask readback", rd_lat, 32'hA5A5_5A5A);
    check("R11 mask sel edge", rd_edg, 32'hA5A5_5A5A);
    reg_read(1'b1);
    check("R11 status sel", rd_lat, 32'h0);

    // R3 / R9 / R10: vector table on the live variant
    foreach (VECS[v]) begin
      reg_write(1'b0, VECS[v].mask);
      irq_lines = VECS[v].lines;
      wait_cyc(3);
      check($sformatf("R9 irq vec%0d", v), {31'b0, irq_liv}, {31'b0, VECS[v].vld});
      check($sformatf("R10 valid vec%0d", v), {31'b0, vld_liv}, {31'b0, VECS[v].vld});
      if (VECS[v].vld)
        check($sformatf("R10 idx vec%0d", v), {27'b0, idx_liv}, {27'b0, VECS[v].idx});
      reg_read(1'b1);
      check($sformatf("R3 live status vec%0d", v), rd_liv, VECS[v].lines);
    end

    // R3: live variant ignores status writes and follows the line
    irq_lines = 32'h0000_00F0;
    wait_cyc(3);
    reg_write(1'b1, 32'h0);
    reg_read(1'b1);
    check("R3 live write ignored", rd_liv, 32'h0000_00F0);
    irq_lines = 32'h0;
    @(negedge clk);
    check("R3 live one edge later", {31'b0, irq_liv}, 32'h1);
    @(negedge clk);
    check("R3 live two edges later", {31'b0, irq_liv}, 32'h0);

    // R4 / R6 hold, R5 / R7 clear polarity
    do_reset();
    reg_write(1'b0, 32'hFFFF_FFFF);
    irq_lines = 32'h0000_0003;
    wait_cyc(4);
    irq_lines = 32'h0;
    wait_cyc(4);
    reg_read(1'b1);
    check("R4 edge held after drop", rd_edg, 32'h0000_0003);
    check("R6 latch held after drop", rd_lat, 32'h0000_0003);
    reg_write(1'b1, 32'h0000_0001);
    reg_read(1'b1);
    check("R5 edge write-one clears", rd_edg, 32'h0000_0002);
    check("R7 latch write-zero clears", rd_lat, 32'h0000_0001);
    reg_write(1'b1, 32'h0);
    reg_read(1'b1);
    check("R5 edge zero keeps", rd_edg, 32'h0000_0002);
    check("R7 latch zero clears", rd_lat, 32'h0);
    reg_write(1'b1, 32'h0000_0002);
    reg_read(1'b1);
    check("R5 edge last clear", rd_edg, 32'h0);

    // R8: set and clear on the same bit in the same cycle
    do_reset();
    reg_write(1'b0, 32'hFFFF_FFFF);
    irq_lines = 32'h0000_0010;
    wait_cyc(4);
    irq_lines = 32'h0;
    wait_cyc(4);
    irq_lines = 32'h0000_0010;
    @(negedge clk);
    @(negedge clk);
    sreg_req = 1'b1; sreg_we = 1'b1; sreg_sel = 1'b1; sreg_wdata = 32'h0000_0010;
    @(negedge clk);
    sreg_req = 1'b0; sreg_we = 1'b0;
    reg_read(1'b1);
    check("R8 edge set beats clear", rd_edg, 32'h0000_0010);
    reg_write(1'b1, 32'h0);
    reg_read(1'b1);
    check("R8 latch level beats clear", rd_lat, 32'h0000_0010);
    irq_lines = 32'h0;
    wait_cyc(4);
    reg_write(1'b1, 32'h0);
    reg_read(1'b1);
    check("R7 latch cleared after drop", rd_lat, 32'h0);

    // R9 / R10 on the latch variant
    do_reset();
    reg_write(1'b0, 32'hFFFF_FF00);
    irq_lines = 32'h0000_8101;
    wait_cyc(4);
    irq_lines = 32'h0;
    wait_cyc(4);
    check("R9 latch irq", {31'b0, irq_lat}, 32'h1);
    check("R10 latch idx low mask", {27'b0, idx_lat}, 32'd8);
    reg_write(1'b0, 32'h0000_8000);
    check("R10 latch idx high", {27'b0, idx_lat}, 32'd15);
    check("R9 edge irq", {31'b0, irq_edg}, 32'h1);
    reg_write(1'b0, 32'h0);
    check("R9 masked irq low", {31'b0, irq_lat}, 32'h0);
    check("R10 masked valid low", {31'b0, vld_lat}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule